// File: doc/BRIEF.md
# Serial Programming Slave with Oversampled Clock

This block lets an external host load and inspect two small on-chip byte arrays, a program array and a data array, over a four-wire serial link: serial clock, host-to-device data, device-to-host data and an active-low session select. The serial clock is not used as a clock. All three host inputs are brought into the core clock domain through two-flop synchronizers, and edges of the serial clock are found by comparing successive synchronized samples. Host data is taken on rising edges and the reply bit changes on falling edges. Each high or low phase of the serial clock must therefore last at least three core cycles.

Every instruction is exactly 32 bits, sent most significant bit first, as four bytes: an opcode, two address bytes and a data byte. A session starts when select goes low. Nothing but the unlock instruction is acted on until the unlock has been accepted. After that the host can erase both arrays to all ones, write either array, read a byte back in the fourth byte slot, and poll a busy flag. Erase and write are self-timed. While they run, the block raises a busy output for a fixed number of core cycles.

Top module: `sprog_slave`

## Requirements
- R1: While reset is high and on the first cycle after it, `miso_o` and `busy_o` are 0, and the unlock state is cleared.
- R2: Host data is captured on rising serial-clock edges, MSB first, in 32-bit frames. During the first two bytes of every frame `miso_o` returns 0. During the third byte it returns the second byte that was received.
- R3: `miso_o` changes only after a detected falling serial-clock edge, or when the session ends.
- R4: While `sel_n_i` is high, the bit counter, the shift register and the reply are held at zero and the unlock is cleared. A partial frame is discarded when select rises.
- R5: Opcode 0xAC with second byte 0x53 unlocks the session. Before that, every other instruction has no effect and its fourth reply byte is 0.
- R6: Opcode 0xC4 (erase) sets every byte of both arrays to 0xFF. Busy then stays high for max(BUSY_CYCLES, 2^ADDR_W) core cycles.
- R7: Opcode 0xC0 (data write) replaces the addressed data-array byte with the fourth byte, with no prior erase needed. Busy stays high for BUSY_CYCLES cycles.
- R8: Opcode 0x40 (program write) stores the bitwise AND of the old byte and the fourth byte, so bits can only be cleared. Busy stays high for BUSY_CYCLES cycles.
- R9: Opcodes 0x20 (program read) and 0xA0 (data read) return the addressed byte in the fourth byte slot. The address is the low ADDR_W bits of {second byte, third byte}.
- R10: Opcode 0xF0 (poll) returns the busy flag in bit 0 of the fourth byte, with all other bits 0.
- R11: An erase or write that completes while busy is high is ignored. A read whose fourth byte starts while busy is high returns 0xFF.
- R12: Frames are received and answered correctly when every serial-clock phase lasts exactly 3 core cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock from the host, asynchronous |
| mosi_i | input | 1 | Serial data from the host, asynchronous |
| sel_n_i | input | 1 | Active-low session select, asynchronous |
| miso_o | output | 1 | Serial reply data, registered |
| busy_o | output | 1 | High while a self-timed erase or write runs |

## Verification
The frame path is driven with clock phases of 3, 4 and 5 core cycles. This separates a correct edge detector from one that misses or double-counts edges at the minimum width. Writes cover both arrays with overlapping bit patterns (0xF0 then 0x3C), which shows whether the program array clears bits or overwrites. Address bytes with high bits set show whether the address is truncated. Commands sent in the middle of a busy window, partial frames cut off by select, and instructions sent before the unlock show whether each is really ignored: the memory contents and the busy timing are read back afterwards.

// File: rtl/sprog_pkg.sv
package sprog_pkg;
  localparam int BYTE_W      = 8;
  localparam int FRAME_BYTES = 4;
  localparam int FRAME_BITS  = BYTE_W * FRAME_BYTES;

  localparam logic [7:0] OP_UNLOCK  = 8'hAC;
  localparam logic [7:0] UNLOCK_KEY = 8'h53;
  localparam logic [7:0] OP_ERASE   = 8'hC4;
  localparam logic [7:0] OP_WR_PROG = 8'h40;
  localparam logic [7:0] OP_WR_DATA = 8'hC0;
  localparam logic [7:0] OP_RD_PROG = 8'h20;
  localparam logic [7:0] OP_RD_DATA = 8'hA0;
  localparam logic [7:0] OP_POLL    = 8'hF0;

  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_ERASE = 2'd1,
    M_WRITE = 2'd2
  } mstate_e;
endpackage

// File: rtl/sprog_sync.sv
module sprog_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[b]}};
      else     chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/sprog_frame.sv
module sprog_frame #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_s,
  input  logic              mosi_s,
  input  logic              sel_n_s,
  input  logic [7:0]        last_byte_i,
  output logic              sck_rise_o,
  output logic              sck_fall_o,
  output logic              sess_act_o,
  output logic              frame_done_o,
  output logic [7:0]        live_op_o,
  output logic [ADDR_W-1:0] live_addr_o,
  output logic [7:0]        done_op_o,
  output logic [7:0]        done_key_o,
  output logic [ADDR_W-1:0] done_addr_o,
  output logic [7:0]        done_data_o,
  output logic              miso_o
);
  import sprog_pkg::*;
  localparam int CNT_W  = $clog2(FRAME_BITS);
  localparam int BIT_W  = $clog2(BYTE_W);

  logic             sck_d;
  logic [CNT_W-1:0] bit_cnt;
  logic [FRAME_BITS-1:0] shreg;
  logic [7:0]       tx_sh;
  logic [7:0]       next_tx;

  always_ff @(posedge clk) begin
    if (rst) sck_d <= 1'b0;
    else     sck_d <= sck_s;
  end

  assign sck_rise_o   = sck_s & ~sck_d;
  assign sck_fall_o   = ~sck_s & sck_d;
  assign sess_act_o   = ~sel_n_s;
  assign frame_done_o = sess_act_o & sck_rise_o & (bit_cnt == CNT_W'(FRAME_BITS-1));

  // fields of the live shift register (valid once three bytes are in)
  assign live_op_o   = shreg[23:16];
  assign live_addr_o = shreg[ADDR_W-1:0];
  // fields of the complete frame, including the bit arriving now
  assign done_op_o   = shreg[30:23];
  assign done_key_o  = shreg[22:15];
  assign done_addr_o = shreg[ADDR_W+6:7];
  assign done_data_o = {shreg[6:0], mosi_s};

  always_comb begin
    case (bit_cnt[CNT_W-1:BIT_W])
      2'd2:    next_tx = shreg[7:0];
      2'd3:    next_tx = last_byte_i;
      default: next_tx = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !sess_act_o) begin
      bit_cnt <= '0;
      shreg   <= '0;
      tx_sh   <= '0;
      miso_o  <= 1'b0;
    end else if (sck_rise_o) begin
      shreg   <= {shreg[FRAME_BITS-2:0], mosi_s};
      bit_cnt <= bit_cnt + 1'b1;
    end else if (sck_fall_o) begin
      if (bit_cnt[BIT_W-1:0] == '0) begin
        miso_o <= next_tx[7];
        tx_sh  <= {next_tx[6:0], 1'b0};
      end else begin
        miso_o <= tx_sh[7];
        tx_sh  <= {tx_sh[6:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/sprog_mem.sv
module sprog_mem #(
  parameter int ADDR_W      = 6,
  parameter int BUSY_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_erase_i,
  input  logic              start_write_i,
  input  logic              to_data_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rd_prog_o,
  output logic [7:0]        rd_data_o,
  output logic              busy_o
);
  import sprog_pkg::*;
  localparam int DEPTH        = 1 << ADDR_W;
  localparam int ERASE_CYCLES = (BUSY_CYCLES > DEPTH) ? BUSY_CYCLES : DEPTH;
  localparam int CNT_W        = $clog2(ERASE_CYCLES + 1);

  logic [7:0] prog_mem [DEPTH];
  logic [7:0] data_mem [DEPTH];

  mstate_e           state;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W:0]   walk;
  logic [ADDR_W-1:0] lat_addr;
  logic [7:0]        lat_data;
  logic              lat_to_data;

  logic              we_prog, we_data;
  logic [ADDR_W-1:0] w_addr, r_addr;
  logic [7:0]        w_prog, w_data;

  always_comb begin
    r_addr  = (state == M_IDLE) ? raddr_i : lat_addr;
    we_prog = 1'b0;
    we_data = 1'b0;
    w_addr  = lat_addr;
    w_prog  = lat_data & rd_prog_o;
    w_data  = lat_data;
    case (state)
      M_ERASE: if (!walk[ADDR_W]) begin
        we_prog = 1'b1;
        we_data = 1'b1;
        w_addr  = walk[ADDR_W-1:0];
        w_prog  = 8'hFF;
        w_data  = 8'hFF;
      end
      M_WRITE: if (cnt == CNT_W'(1)) begin
        we_data = lat_to_data;
        we_prog = ~lat_to_data;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (we_prog) prog_mem[w_addr] <= w_prog;
    rd_prog_o <= prog_mem[r_addr];
  end

  always_ff @(posedge clk) begin
    if (we_data) data_mem[w_addr] <= w_data;
    rd_data_o <= data_mem[r_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= M_IDLE;
      cnt         <= '0;
      walk        <= '0;
      lat_addr    <= '0;
      lat_data    <= '0;
      lat_to_data <= 1'b0;
      busy_o      <= 1'b0;
    end else if (state == M_IDLE) begin
      if (start_erase_i) begin
        state  <= M_ERASE;
        cnt    <= CNT_W'(ERASE_CYCLES);
        walk   <= '0;
        busy_o <= 1'b1;
      end else if (start_write_i) begin
        state       <= M_WRITE;
        cnt         <= CNT_W'(BUSY_CYCLES);
        lat_addr    <= waddr_i;
        lat_data    <= wdata_i;
        lat_to_data <= to_data_i;
        busy_o      <= 1'b1;
      end
    end else begin
      if (!walk[ADDR_W]) walk <= walk + 1'b1;
      if (cnt == CNT_W'(1)) begin
        state  <= M_IDLE;
        busy_o <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sprog_slave.sv
module sprog_slave #(
  parameter int ADDR_W      = 6,
  parameter int BUSY_CYCLES = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_i,
  input  logic mosi_i,
  input  logic sel_n_i,
  output logic miso_o,
  output logic busy_o
);
  import sprog_pkg::*;

  logic [2:0] pins_s;
  logic       sck_rise, sck_fall, sess_act, frame_done;
  logic       en_q;
  logic [7:0] live_op, done_op, done_key, done_data, last_byte;
  logic [ADDR_W-1:0] live_addr, done_addr;
  logic [7:0] rd_prog, rd_data;
  logic       go_erase, go_write, go_data;

  sprog_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({sel_n_i, mosi_i, sck_i}),
    .q_o (pins_s)
  );

  sprog_frame #(.ADDR_W(ADDR_W)) u_frame (
    .clk          (clk),
    .rst          (rst),
    .sck_s        (pins_s[0]),
    .mosi_s       (pins_s[1]),
    .sel_n_s      (pins_s[2]),
    .last_byte_i  (last_byte),
    .sck_rise_o   (sck_rise),
    .sck_fall_o   (sck_fall),
    .sess_act_o   (sess_act),
    .frame_done_o (frame_done),
    .live_op_o    (live_op),
    .live_addr_o  (live_addr),
    .done_op_o    (done_op),
    .done_key_o   (done_key),
    .done_addr_o  (done_addr),
    .done_data_o  (done_data),
    .miso_o       (miso_o)
  );

  always_ff @(posedge clk) begin
    if (rst || !sess_act) en_q <= 1'b0;
    else if (frame_done && done_op == OP_UNLOCK && done_key == UNLOCK_KEY) en_q <= 1'b1;
  end

  assign go_data  = (done_op == OP_WR_DATA);
  assign go_erase = frame_done && en_q && !busy_o && (done_op == OP_ERASE);
  assign go_write = frame_done && en_q && !busy_o &&
                    ((done_op == OP_WR_PROG) || go_data);

  always_comb begin
    last_byte = 8'h00;
    if (en_q) begin
      case (live_op)
        OP_RD_PROG: last_byte = busy_o ? 8'hFF : rd_prog;
        OP_RD_DATA: last_byte = busy_o ? 8'hFF : rd_data;
        OP_POLL:    last_byte = {7'b0, busy_o};
        default:    last_byte = 8'h00;
      endcase
    end
  end

  sprog_mem #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES)) u_mem (
    .clk           (clk),
    .rst           (rst),
    .start_erase_i (go_erase),
    .start_write_i (go_write),
    .to_data_i     (go_data),
    .waddr_i       (done_addr),
    .wdata_i       (done_data),
    .raddr_i       (live_addr),
    .rd_prog_o     (rd_prog),
    .rd_data_o     (rd_data),
    .busy_o        (busy_o)
  );
endmodule

// File: rtl/sprog_slave_chk.sv
module sprog_slave_chk #(
  parameter int ADDR_W      = 6,
  parameter int BUSY_CYCLES = 40
) (
  input logic clk,
  input logic rst,
  input logic miso_o,
  input logic busy_o,
  input logic sck_fall,
  input logic sess_act,
  input logic frame_done,
  input logic en_q
);
  localparam int DEPTH        = 1 << ADDR_W;
  localparam int ERASE_CYCLES = (BUSY_CYCLES > DEPTH) ? BUSY_CYCLES : DEPTH;

  logic [31:0] run_len;
  always_ff @(posedge clk) begin
    if (rst)         run_len <= '0;
    else if (busy_o) run_len <= run_len + 1'b1;
    else             run_len <= '0;
  end

  // R1
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> (!busy_o && !miso_o && !en_q));

  // R3
  a_r3_miso_on_fall: assert property (@(posedge clk) disable iff (rst)
    (sess_act && !sck_fall) |=> $stable(miso_o));

  // R4
  a_r4_idle_reply_low: assert property (@(posedge clk) disable iff (rst)
    !sess_act |=> (!miso_o && !en_q));

  // R5
  a_r5_locked_no_start: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !en_q && !busy_o) |=> !busy_o);

  // R5, R11: busy only starts from an accepted frame
  a_r5_start_from_frame: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(frame_done && en_q));

  // R6, R7, R8, R11
  a_r6_busy_len: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (run_len == 32'(BUSY_CYCLES) || run_len == 32'(ERASE_CYCLES)));
endmodule

bind sprog_slave sprog_slave_chk #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .miso_o     (miso_o),
  .busy_o     (busy_o),
  .sck_fall   (sck_fall),
  .sess_act   (sess_act),
  .frame_done (frame_done),
  .en_q       (en_q)
);

// File: tb/sim_sprog_slave.sv
`timescale 1ns/1ps
module sim_sprog_slave;
  localparam int AW        = 6;
  localparam int DEPTH     = 1 << AW;
  localparam int BUSY_LEN  = 600;
  localparam int ERASE_LEN = (BUSY_LEN > DEPTH) ? BUSY_LEN : DEPTH;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, mosi = 1'b0, sel_n = 1'b1;
  logic miso_o, busy_o;

  always #2 clk = ~clk;

  sprog_slave #(.ADDR_W(AW), .BUSY_CYCLES(BUSY_LEN)) u0 (
    .clk(clk), .rst(rst), .sck_i(sck), .mosi_i(mosi), .sel_n_i(sel_n),
    .miso_o(miso_o), .busy_o(busy_o)
  );

  int tests = 0, fails = 0, prints = 0;
  bit done = 1'b0;

  // behavioural reference state
  logic [7:0] prog_m [DEPTH];
  logic [7:0] data_m [DEPTH];
  bit en_m = 1'b0;
  int cyc = 0, busy_left = 0, start_at = -1, cmd_kind = 0;
  int cmd_addr = 0;
  logic [7:0] cmd_data = 8'h00;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      if (prints < 20) $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      prints++;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == start_at && busy_left == 0 && cmd_kind != 0) begin
      case (cmd_kind)
        1: begin
          for (int a = 0; a < DEPTH; a++) begin prog_m[a] = 8'hFF; data_m[a] = 8'hFF; end
          busy_left = ERASE_LEN;
        end
        2: begin prog_m[cmd_addr] = prog_m[cmd_addr] & cmd_data; busy_left = BUSY_LEN; end
        default: begin data_m[cmd_addr] = cmd_data; busy_left = BUSY_LEN; end
      endcase
    end else if (busy_left > 0) begin
      busy_left--;
    end
  end

  // busy compared with the model on every clock (R6, R7, R8, R11)
  always @(negedge clk) begin
    if (!rst && !done) check(busy_o == (busy_left > 0), "R6/R7/R8 busy", busy_o, busy_left > 0);
  end

  task automatic sess_on();
    sel_n = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic sess_off();
    sel_n = 1'b1;
    en_m  = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] b0, b1, b2, b3, input int h, input string req);
    logic [31:0] w, rx;
    logic [7:0] exp3;
    int a;
    w = {b0, b1, b2, b3};
    a = int'({b1, b2}) % DEPTH;
    exp3 = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      if (i == 7 && en_m) begin
        case (b0)
          8'h20: exp3 = (busy_left > 0) ? 8'hFF : prog_m[a];
          8'hA0: exp3 = (busy_left > 0) ? 8'hFF : data_m[a];
          8'hF0: exp3 = {7'b0, busy_left > 0};
          default: exp3 = 8'h00;
        endcase
      end
      mosi = w[i];
      repeat (h) @(negedge clk);
      rx[i] = miso_o;
      sck = 1'b1;
      if (i == 0) begin
        cmd_kind = 0;
        if (en_m) begin
          if (b0 == 8'hC4) cmd_kind = 1;
          else if (b0 == 8'h40) cmd_kind = 2;
          else if (b0 == 8'hC0) cmd_kind = 3;
        end
        cmd_addr = a;
        cmd_data = b3;
        start_at = cyc + 3;
        if (b0 == 8'hAC && b1 == 8'h53) en_m = 1'b1;
      end
      repeat (h) @(negedge clk);
      sck = 1'b0;
    end
    check(rx[31:24] == 8'h00, "R2 byte0", rx[31:24], 0);
    check(rx[23:16] == 8'h00, "R2 byte1", rx[23:16], 0);
    check(rx[15:8] == b1, "R2 echo", rx[15:8], b1);
    check(rx[7:0] == exp3, req, rx[7:0], exp3);
  endtask

  task automatic wait_idle();
    repeat (4) @(negedge clk);
    while (busy_left > 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(miso_o == 1'b0, "R1 miso", miso_o, 0);
    check(busy_o == 1'b0, "R1 busy", busy_o, 0);
    rst = 1'b0;
    @(negedge clk);
    check(miso_o == 1'b0 && busy_o == 1'b0, "R1 after", {miso_o, busy_o}, 0);

    // R5: locked session ignores erase, read returns 0
    sess_on();
    frame(8'hC4, 8'h00, 8'h00, 8'h00, 4, "R5 locked erase");
    repeat (10) @(negedge clk);
    check(busy_o == 1'b0, "R5 no busy", busy_o, 0);
    frame(8'hA0, 8'h00, 8'h05, 8'h00, 4, "R5 locked read");

    // R4: partial frame dropped when select rises
    for (int i = 0; i < 12; i++) begin
      mosi = i[0];
      repeat (4) @(negedge clk); sck = 1'b1;
      repeat (4) @(negedge clk); sck = 1'b0;
    end
    sess_off();
    check(miso_o == 1'b0, "R4 idle miso", miso_o, 0);
    sess_on();
    frame(8'hAC, 8'h53, 8'h00, 8'h00, 3, "R12 unlock");
    frame(8'hF0, 8'h00, 8'h00, 8'h00, 5, "R4 R10 poll idle");

    // R6 erase, poll during busy
    frame(8'hC4, 8'h00, 8'h00, 8'h00, 3, "R6 erase");
    frame(8'hF0, 8'h00, 8'h00, 8'h00, 3, "R10 poll busy");
    wait_idle();
    frame(8'h20, 8'h00, 8'h3F, 8'h00, 4, "R6 prog FF");
    frame(8'hA0, 8'h00, 8'h00, 8'h00, 4, "R6 data FF");

    // R7 data replace
    frame(8'hC0, 8'h00, 8'h05, 8'h3C, 4, "R7 wr");
    wait_idle();
    frame(8'hA0, 8'h00, 8'h05, 8'h00, 4, "R7 rd 3C");
    frame(8'hC0, 8'h00, 8'h05, 8'hC3, 4, "R7 wr2");
    wait_idle();
    frame(8'hA0, 8'h00, 8'h05, 8'h00, 5, "R7 rd C3");

    // R8 program AND
    frame(8'h40, 8'h00, 8'h09, 8'hF0, 4, "R8 wr");
    wait_idle();
    frame(8'h40, 8'h00, 8'h09, 8'h3C, 4, "R8 wr2");
    wait_idle();
    frame(8'h20, 8'h00, 8'h09, 8'h00, 4, "R8 rd 30");

    // R9 address truncation
    frame(8'h20, 8'hFF, 8'h09, 8'h00, 4, "R9 rd trunc");
    frame(8'hC0, 8'h12, 8'h45, 8'h77, 4, "R9 wr trunc");
    wait_idle();
    frame(8'hA0, 8'h00, 8'h05, 8'h00, 4, "R9 rd 77");

    // R11 commands during busy
    frame(8'hC0, 8'h00, 8'h07, 8'h11, 3, "R11 wr");
    frame(8'hC0, 8'h00, 8'h07, 8'h22, 3, "R11 wr ignored");
    frame(8'hA0, 8'h00, 8'h07, 8'h00, 3, "R11 rd busy FF");
    wait_idle();
    frame(8'hA0, 8'h00, 8'h07, 8'h00, 4, "R11 rd 11");

    // R4 unlock cleared by session end
    sess_off();
    sess_on();
    frame(8'hC0, 8'h00, 8'h05, 8'h00, 4, "R4 relock wr");
    repeat (10) @(negedge clk);
    check(busy_o == 1'b0, "R4 relock busy", busy_o, 0);
    frame(8'hAC, 8'h53, 8'h00, 8'h00, 4, "R5 unlock2");
    frame(8'hA0, 8'h00, 8'h05, 8'h00, 4, "R4 rd kept 77");
    sess_off();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule